// File: doc/BRIEF.md
# Engine State Scan Port

This block gives a host a way to freeze-dry the internal state of a legacy sound engine and bring it back later, for suspend and resume. The engine's state flip-flops are strung into one serial shift chain of 218 bits. The block drives that chain's tap: a capture strobe copies the live flip-flops into the chain, a shift enable moves it one bit per clock, and a load strobe copies the chain back into the live flip-flops. The host sees only a byte-wide index/data register pair. It selects the scan index and then reads or writes the data register once per byte.

To save state, the host selects the scan index, which captures the engine and rewinds the byte pointer. It then reads 28 bytes. Each read rotates eight chain bits (two on the final byte) past the tap and feeds them back in, so the chain is intact once the sequence ends. To restore state, the host selects the scan index and writes the same 28 bytes back. After the last byte has been shifted in, the block pulses the load strobe. A second index exposes the engine's pending-interrupt flag as a read-only register.

Every data access starts a short serial burst. While a burst, capture or load is in flight, the block ignores all host accesses. A read reports its byte with a one-cycle valid pulse.

Top module: `scan_state_port`

## Requirements
- R1: After reset the read data is 00h, no read-valid, capture, load or shift is active, the index register reads 00h, and the interrupt flag register reads 00h while the engine interrupt input is low.
- R2: Writing F1h to the index register (offset 4) produces exactly one single-cycle capture pulse with no shifting. It also rewinds the byte pointer, so the next scan data access addresses byte 0.
- R3: A data read (offset 5) with index F1h makes 8 shift cycles and returns the next 8 chain bits LSB-first. The bit that leaves the chain first lands in data bit 0.
- R4: Byte 27, the final byte, makes only 2 shift cycles. Its two bits land in data bits 1:0 and bits 7:2 read 0.
- R5: Scan reads feed every outgoing chain bit back into the chain input, so after 28 reads the chain holds exactly the captured state.
- R6: A data write with index F1h shifts the written byte into the chain LSB-first, 8 bits per write and only bits 1:0 on byte 27, ignoring bits 7:2 there. After the 28th write a single load pulse transfers the written state into the engine.
- R7: With index F8h, a data read returns the engine interrupt flag in bit 0 with bits 7:1 zero, and a data write has no effect.
- R8: With any index other than F1h or F8h, data reads return 00h, and data reads and writes shift nothing and leave the chain untouched.
- R9: Host accesses presented while a burst, capture or load is in progress are ignored.
- R10: After byte 27 the byte pointer wraps, so a 29th read returns byte 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access strobe, one cycle |
| host_rd | input | 1 | Read qualifier |
| host_wr | input | 1 | Write qualifier (wins over read) |
| host_addr | input | 3 | Register offset: 4 index, 5 data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle pulse when read data is ready |
| eng_irq | input | 1 | Engine pending-interrupt level |
| chain_so | input | 1 | Serial output of the engine's state chain |
| chain_si | output | 1 | Serial input to the engine's state chain |
| chain_shift | output | 1 | Chain shifts one bit on this clock |
| chain_capture | output | 1 | Copy engine flip-flops into the chain |
| chain_load | output | 1 | Copy the chain into the engine flip-flops |

## Verification
A wrong bit pointer or burst length shows up at once as a wrong shift count on the very next scan access. A rotation fault only shows as a corrupted chain after a complete 28-byte pass, or as a differing byte when the same state is read a second time. A wrong write bit order stays hidden until the load strobe and the read-back that follows it, so the bench compares the whole engine state after every restore. A fault in the busy gating shows one access later, as a shifted index register or an extra burst.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } scan_dir_e;
endpackage

// File: rtl/scan_port_regs.sv
module scan_port_regs
    import scan_port_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          ADDR_W   = 3,
    parameter int unsigned IDX_OFS  = 4,
    parameter int unsigned DAT_OFS  = 5,
    parameter int unsigned SCAN_IDX = 8'hF1,
    parameter int unsigned IRQ_IDX  = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              blocked,
    input  logic              eng_irq,
    input  logic              scan_done_rd,
    input  logic [DATA_W-1:0] scan_byte,
    output logic              scan_go,
    output scan_dir_e         scan_dir,
    output logic              scan_select,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_OFS);
    localparam logic [ADDR_W-1:0] DAT_A  = ADDR_W'(DAT_OFS);
    localparam logic [DATA_W-1:0] SCAN_V = DATA_W'(SCAN_IDX);
    localparam logic [DATA_W-1:0] IRQ_V  = DATA_W'(IRQ_IDX);

    typedef struct packed {
        logic [DATA_W-1:0] idx;
        logic              irq;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } regs_t;

    regs_t q, d;
    logic  acc, wr_acc, rd_acc, scan_hit;

    always_comb begin
        acc         = host_cs && !blocked;
        wr_acc      = acc && host_wr;
        rd_acc      = acc && host_rd && !host_wr;
        scan_hit    = (host_addr == DAT_A) && (q.idx == SCAN_V);
        scan_go     = (wr_acc || rd_acc) && scan_hit;
        scan_dir    = wr_acc ? DIR_WRITE : DIR_READ;
        scan_select = wr_acc && (host_addr == IDX_A) && (host_wdata == SCAN_V);

        d        = q;
        d.irq    = eng_irq;
        d.rvalid = 1'b0;
        if (wr_acc && host_addr == IDX_A) begin
            d.idx = host_wdata;
        end
        if (rd_acc && !scan_hit) begin
            d.rvalid = 1'b1;
            if (host_addr == IDX_A) begin
                d.rdata = q.idx;
            end else if (host_addr == DAT_A && q.idx == IRQ_V) begin
                d.rdata = {{(DATA_W-1){1'b0}}, q.irq};
            end else begin
                d.rdata = '0;
            end
        end
        if (scan_done_rd) begin
            d.rvalid = 1'b1;
            d.rdata  = scan_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;

    AST_RVALID_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> $past(rd_acc) || $past(scan_done_rd)); // R3
endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter int STATE_BITS = 218,
    parameter int DATA_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scan_go,
    input  scan_dir_e                 scan_dir,
    input  logic                      scan_select,
    output logic                      shift_en,
    output logic [$clog2(DATA_W)-1:0] bit_pos,
    output scan_dir_e                 dir,
    output logic                      done_rd,
    output logic                      blocked,
    output logic                      capture,
    output logic                      load
);
    localparam int BYTES     = (STATE_BITS + DATA_W - 1) / DATA_W;
    localparam int LAST_BITS = STATE_BITS - (BYTES - 1) * DATA_W;
    localparam int POS_W     = $clog2(DATA_W);
    localparam int BYTE_W    = $clog2(BYTES);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BYTES - 1);

    typedef struct packed {
        logic              busy;
        scan_dir_e         dir;
        logic [POS_W-1:0]  pos;
        logic [BYTE_W-1:0] byte_idx;
        logic              done;
        logic              capture;
        logic              load;
    } ctrl_t;

    ctrl_t            q, d;
    logic             last_byte;
    logic [POS_W-1:0] pos_end;

    always_comb begin
        last_byte = (q.byte_idx == LAST_BYTE);
        pos_end   = last_byte ? POS_W'(LAST_BITS - 1) : POS_W'(DATA_W - 1);

        d         = q;
        d.done    = 1'b0;
        d.capture = 1'b0;
        d.load    = 1'b0;
        if (scan_select) begin
            d.capture  = 1'b1;
            d.byte_idx = '0;
        end else if (scan_go) begin
            d.busy = 1'b1;
            d.pos  = '0;
            d.dir  = scan_dir;
        end
        if (q.busy) begin
            d.pos = q.pos + 1'b1;
            if (q.pos == pos_end) begin
                d.busy     = 1'b0;
                d.done     = 1'b1;
                d.byte_idx = last_byte ? '0 : q.byte_idx + 1'b1;
                d.load     = (q.dir == DIR_WRITE) && last_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign shift_en = q.busy;
    assign bit_pos  = q.pos;
    assign dir      = q.dir;
    assign done_rd  = q.done && (q.dir == DIR_READ);
    assign blocked  = q.busy || q.done || q.capture || q.load;
    assign capture  = q.capture;
    assign load     = q.load;

    AST_POINTER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.byte_idx <= LAST_BYTE); // R10
    AST_TAIL_BURST_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && last_byte) |-> (q.pos < POS_W'(LAST_BITS))); // R4
endmodule

// File: rtl/scan_port_shifter.sv
module scan_port_shifter
    import scan_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      shift_en,
    input  logic [$clog2(DATA_W)-1:0] bit_pos,
    input  scan_dir_e                 dir,
    input  logic                      so,
    output logic                      si,
    output logic [DATA_W-1:0]         byte_out
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] wbuf;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.wbuf = wdata;
            d.hold = '0;
        end
        if (shift_en && dir == DIR_READ) begin
            d.hold[bit_pos] = so;
        end
        si = (dir == DIR_WRITE) ? q.wbuf[bit_pos] : so;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign byte_out = q.hold;

    AST_BUFFER_STEADY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && $past(shift_en)) |-> $stable(q.wbuf)); // R6
endmodule

// File: rtl/scan_state_port.sv
module scan_state_port
    import scan_port_pkg::*;
#(
    parameter int          STATE_BITS = 218,
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 3,
    parameter int unsigned IDX_OFS    = 4,
    parameter int unsigned DAT_OFS    = 5,
    parameter int unsigned SCAN_IDX   = 8'hF1,
    parameter int unsigned IRQ_IDX    = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              eng_irq,
    input  logic              chain_so,
    output logic              chain_si,
    output logic              chain_shift,
    output logic              chain_capture,
    output logic              chain_load
);
    localparam int POS_W = $clog2(DATA_W);

    logic              scan_go, scan_select, blocked, done_rd;
    scan_dir_e         req_dir, run_dir;
    logic [POS_W-1:0]  bit_pos;
    logic [DATA_W-1:0] scan_byte;

    scan_port_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS),
        .DAT_OFS(DAT_OFS), .SCAN_IDX(SCAN_IDX), .IRQ_IDX(IRQ_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .blocked(blocked), .eng_irq(eng_irq), .scan_done_rd(done_rd),
        .scan_byte(scan_byte), .scan_go(scan_go), .scan_dir(req_dir),
        .scan_select(scan_select), .rdata(host_rdata), .rvalid(host_rvalid)
    );

    scan_port_ctrl #(
        .STATE_BITS(STATE_BITS), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .scan_dir(req_dir),
        .scan_select(scan_select), .shift_en(chain_shift), .bit_pos(bit_pos),
        .dir(run_dir), .done_rd(done_rd), .blocked(blocked),
        .capture(chain_capture), .load(chain_load)
    );

    scan_port_shifter #(
        .DATA_W(DATA_W)
    ) u_shf (
        .clk(clk), .rst_n(rst_n), .start(scan_go), .wdata(host_wdata),
        .shift_en(chain_shift), .bit_pos(bit_pos), .dir(run_dir),
        .so(chain_so), .si(chain_si), .byte_out(scan_byte)
    );

    AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_capture |=> !chain_capture); // R2
    AST_CAPTURE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_capture |-> !chain_shift); // R2
    AST_LOAD_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_load |-> $past(chain_shift)); // R6
    AST_NO_RVALID_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        chain_shift |-> !host_rvalid); // R9
endmodule

// File: tb/scan_state_port_test.sv
module scan_state_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 218;
    localparam int NBYTES = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 0, host_rd = 0, host_wr = 0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic       eng_irq = 1'b0;
    logic       chain_si, chain_shift, chain_capture, chain_load, chain_so;

    logic [NB-1:0] chain, flops, pat_a, pat_b;
    int errors = 0, checks = 0;
    int shift_cnt = 0, cap_cnt = 0, load_cnt = 0, rot_err = 0;
    int cycles = 0;
    logic reading = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_state_port uut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .eng_irq(eng_irq),
        .chain_so(chain_so), .chain_si(chain_si), .chain_shift(chain_shift),
        .chain_capture(chain_capture), .chain_load(chain_load)
    );

    // behavioural engine: live flip-flops plus a serial chain
    assign chain_so = chain[0];
    always @(posedge clk) begin
        if (chain_capture)      chain <= flops;
        else if (chain_shift)   chain <= {chain_si, chain[NB-1:1]};
        if (chain_load)         flops <= chain;
    end

    // per-clock observation of the tap
    always @(negedge clk) begin
        cycles++;
        if (chain_shift)   shift_cnt++;
        if (chain_capture) cap_cnt++;
        if (chain_load)    load_cnt++;
        if (reading && chain_shift && chain_si !== chain_so) rot_err++; // R5
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 50000) begin
            errors++; checks++;
            $display("FAIL watchdog: act=%0d exp<=50000 cycles", cycles);
            summary();
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [NB-1:0] v, input int k);
        logic [7:0] r = '0;
        for (int b = 0; b < 8; b++) if (8*k + b < NB) r[b] = v[8*k + b];
        return r;
    endfunction

    task automatic hwrite(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_cs = 0; host_wr = 0;
        repeat (12) @(negedge clk);
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] v);
        int n = 0;
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_addr = a;
        @(negedge clk);
        host_cs = 0; host_rd = 0;
        while (!host_rvalid && n < 40) begin @(negedge clk); n++; end
        v = host_rdata;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int s0;
        for (int i = 0; i < NB; i++) begin
            pat_a[i] = ((i * 7 + 3) % 5) < 2;
            pat_b[i] = ((i % 3) == 0) ^ (i > 100);
        end
        flops = pat_a;
        chain = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(host_rdata == 8'h00 && !host_rvalid, "R1 rdata/rvalid", {host_rvalid, host_rdata}, 0);
        check(!chain_capture && !chain_load && !chain_shift, "R1 strobes",
              {chain_capture, chain_load, chain_shift}, 0);
        rst_n = 1'b1;
        hread(3'd4, v);
        check(v == 8'h00, "R1 index reset", v, 0);
        hwrite(3'd4, 8'hF8);
        hread(3'd5, v);
        check(v == 8'h00, "R1 irq flag reset", v, 0);
        // R7 interrupt flag
        eng_irq = 1'b1;
        repeat (3) @(negedge clk);
        hread(3'd5, v);
        check(v == 8'h01, "R7 irq set", v, 8'h01);
        s0 = shift_cnt;
        hwrite(3'd5, 8'hFE);
        hread(3'd5, v);
        check(v == 8'h01 && shift_cnt == s0, "R7 write ignored", v, 8'h01);
        eng_irq = 1'b0;
        // R8 other index
        chain = pat_b;
        hwrite(3'd4, 8'h22);
        s0 = shift_cnt;
        hread(3'd5, v);
        check(v == 8'h00, "R8 read zero", v, 0);
        hwrite(3'd5, 8'hA5);
        check(shift_cnt == s0 && chain == pat_b, "R8 no shift", shift_cnt - s0, 0);
        // R2 select and capture
        s0 = cap_cnt;
        hwrite(3'd4, 8'hF1);
        check(cap_cnt == s0 + 1, "R2 capture pulse", cap_cnt - s0, 1);
        check(chain == pat_a, "R2 chain captured", chain[31:0], pat_a[31:0]);
        // R3/R4 full save
        reading = 1'b1;
        for (int k = 0; k < NBYTES; k++) begin
            s0 = shift_cnt;
            hread(3'd5, v);
            check(v == byte_of(pat_a, k), (k == NBYTES-1) ? "R4 tail byte" : "R3 byte", v, byte_of(pat_a, k));
            check(shift_cnt - s0 == ((k == NBYTES-1) ? 2 : 8), (k == NBYTES-1) ? "R4 tail shifts" : "R3 shifts",
                  shift_cnt - s0, (k == NBYTES-1) ? 2 : 8);
        end
        check(chain == pat_a, "R5 chain intact", chain[31:0], pat_a[31:0]);
        // R10 wrap
        hread(3'd5, v);
        check(v == byte_of(pat_a, 0), "R10 wrap", v, byte_of(pat_a, 0));
        // R2 pointer rewind mid-sequence
        hread(3'd5, v);
        hread(3'd5, v);
        hwrite(3'd4, 8'hF1);
        hread(3'd5, v);
        check(v == byte_of(pat_a, 0), "R2 rewind", v, byte_of(pat_a, 0));
        check(rot_err == 0, "R5 feedback", rot_err, 0);
        reading = 1'b0;
        // R6 restore
        hwrite(3'd4, 8'hF1);
        s0 = load_cnt;
        for (int k = 0; k < NBYTES; k++) begin
            hwrite(3'd5, (k == NBYTES-1) ? (byte_of(pat_b, k) | 8'hFC) : byte_of(pat_b, k));
            if (k == NBYTES-2) check(load_cnt == s0, "R6 no early load", load_cnt - s0, 0);
        end
        check(load_cnt == s0 + 1, "R6 load pulse", load_cnt - s0, 1);
        check(flops == pat_b, "R6 state restored", flops[31:0], pat_b[31:0]);
        check(flops[NB-1:NB-32] == pat_b[NB-1:NB-32], "R6 tail bits", flops[NB-1:NB-32], pat_b[NB-1:NB-32]);
        hwrite(3'd4, 8'hF1);
        hread(3'd5, v);
        check(v == byte_of(pat_b, 0), "R6 read back", v, byte_of(pat_b, 0));
        // R9 access during burst ignored
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_addr = 3'd5;
        @(negedge clk);
        host_cs = 0; host_rd = 0;
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_addr = 3'd4; host_wdata = 8'h00;
        @(negedge clk);
        host_cs = 0; host_wr = 0;
        repeat (12) @(negedge clk);
        hread(3'd4, v);
        check(v == 8'hF1, "R9 index kept", v, 8'hF1);
        hread(3'd5, v);
        check(v == byte_of(pat_b, 2), "R9 pointer", v, byte_of(pat_b, 2));
        summary();
    end
endmodule